// File: doc/BRIEF.md
# Three-Channel Auto Channel Gating

This block decides which of three receive channels may feed demodulated data into one merged data output. Each channel's demodulated data bit enters through a two-flop synchronizer. A reception period begins on a soft reset or an inactivity timeout. At that point a settling counter is loaded and then counts ticks of a slow timebase, nominally 32 kHz, given as a one-cycle enable. When the counter expires, the block takes one sample of every synchronized channel bit. If auto selection was enabled when the period began, the sample becomes a per-channel pass mask: a channel that was high keeps passing and a channel that was low is blocked until the next period begins.

The pass mask also serves as a 3-bit status field. The gated channel bits are ORed into the single data output. The carrier-clock and signal-strength paths ignore the mask. After power-on reset no period is running and every channel passes. Settling starts only at the first soft reset or inactivity timeout.

Top module: `auto_chan_gate`

## Requirements
- R1: After reset, status_o is 3'b111 (bit n = 1 means channel n passes). With all demodulated inputs low, data_o is 0.
- R2: A pulse on soft_rst_i or inact_to_i sets status_o to 3'b111 at the clock edge where the pulse is sampled. This re-enables every blocked channel.
- R3: Until the settling counter has seen SETTLE_TICKS ticks (tick_i high at a clock edge), status_o stays 3'b111.
- R4: If auto_en_i was high at the edge that started the period, the edge with the SETTLE_TICKS-th tick loads status_o with the synchronized demodulated bits. Bit n is 1 if channel n was high at that sample.
- R5: If auto_en_i was low at the edge that started the period, status_o stays 3'b111 through the whole period. A change of auto_en_i during a period has no effect until the next period starts.
- R6: The sample is taken once per period. Later changes of demod_i and later ticks leave status_o unchanged until a new period starts. No bit of status_o goes from 0 to 1 except through R2.
- R7: data_o is the OR over channels of (synchronized demod_i[n] AND status_o[n]). A change on demod_i reaches data_o two clock edges later.
- R8: carrier_o is the OR of carrier_i, and rssi_o equals rssi_i, whatever the value of status_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable from the slow timebase |
| soft_rst_i | input | 1 | Soft reset; starts a new reception period |
| inact_to_i | input | 1 | Inactivity timeout; starts a new reception period |
| auto_en_i | input | 1 | Auto selection enable, latched at period start |
| demod_i | input | 3 | Demodulated data bit per channel, asynchronous |
| carrier_i | input | 3 | Carrier clock per channel |
| rssi_i | input | 8 | Signal-strength value |
| data_o | output | 1 | Gated and merged data |
| carrier_o | output | 1 | Merged carrier clock, never gated |
| rssi_o | output | 8 | Signal strength, never gated |
| status_o | output | 3 | Per-channel pass mask |

## Verification
Inputs change on the falling clock edge and outputs are read on the next falling edge. That makes the timing rules concrete:
- status_o is due one edge after a period-start pulse, and one edge after the final settling tick.
- data_o is due two edges after a demod_i change, because of the synchronizer.
- carrier_o and rssi_o are due within the same cycle.

The bench sweeps all eight channel patterns with the enable on and with it off. For each resulting mask it sweeps all eight data patterns, and computes the expected OR arithmetically. It reads status_o one tick before expiry to confirm the mask has not yet moved.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int unsigned ACG_NCH = 3;
  localparam int unsigned ACG_SETTLE_TICKS = 96;
  localparam int unsigned ACG_RSSI_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_HELD   = 2'd2
  } acg_phase_e;
endpackage

// File: rtl/acg_sync.sv
module acg_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/acg_settle_timer.sv
module acg_settle_timer
  import acg_pkg::*;
#(
  parameter int unsigned TICKS = ACG_SETTLE_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  input  logic en_i,
  output logic en_q_o,
  output logic sample_o
);
  localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  acg_phase_e ph_q;
  logic [CW-1:0] cnt_q;
  logic en_q;

  // expiry: last tick of the settling window
  assign sample_o = !restart_i && (ph_q == PH_SETTLE) && tick_i && (cnt_q == ONE);
  assign en_q_o   = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= LOAD;
      en_q  <= 1'b0;
    end else if (restart_i) begin
      ph_q  <= PH_SETTLE;
      cnt_q <= LOAD;
      en_q  <= en_i;
    end else if (ph_q == PH_SETTLE && tick_i) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) ph_q <= PH_HELD;
    end
  end
endmodule

// File: rtl/acg_pass_mask.sv
module acg_pass_mask #(
  parameter int unsigned NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic           sample_i,
  input  logic           en_i,
  input  logic [NCH-1:0] dem_i,
  output logic [NCH-1:0] mask_o
);
  logic [NCH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mask_q <= '1;
    else if (restart_i)         mask_q <= '1;
    else if (sample_i && en_i)  mask_q <= dem_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/auto_chan_gate.sv
module auto_chan_gate
  import acg_pkg::*;
#(
  parameter int unsigned NCH          = ACG_NCH,
  parameter int unsigned SETTLE_TICKS = ACG_SETTLE_TICKS,
  parameter int unsigned RSSI_W       = ACG_RSSI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              soft_rst_i,
  input  logic              inact_to_i,
  input  logic              auto_en_i,
  input  logic [NCH-1:0]    demod_i,
  input  logic [NCH-1:0]    carrier_i,
  input  logic [RSSI_W-1:0] rssi_i,
  output logic              data_o,
  output logic              carrier_o,
  output logic [RSSI_W-1:0] rssi_o,
  output logic [NCH-1:0]    status_o
);
  logic [NCH-1:0] dem_s;
  logic [NCH-1:0] gated;
  logic restart, smp_pulse, en_q;

  assign restart = soft_rst_i | inact_to_i;

  acg_sync #(.W(NCH)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(demod_i), .q_o(dem_s)
  );

  acg_settle_timer #(.TICKS(SETTLE_TICKS)) i_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .tick_i(tick_i),
    .en_i(auto_en_i), .en_q_o(en_q), .sample_o(smp_pulse)
  );

  acg_pass_mask #(.NCH(NCH)) i_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .sample_i(smp_pulse),
    .en_i(en_q), .dem_i(dem_s), .mask_o(status_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_gate
    assign gated[g] = dem_s[g] & status_o[g];
  end

  assign data_o    = |gated;
  // non-data paths bypass the mask
  assign carrier_o = |carrier_i;
  assign rssi_o    = rssi_i;
endmodule

// File: rtl/auto_chan_gate_chk.sv
module auto_chan_gate_chk #(
  parameter int unsigned NCH = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           soft_rst_i,
  input logic           inact_to_i,
  input logic           smp_pulse,
  input logic           data_o,
  input logic           carrier_o,
  input logic [NCH-1:0] carrier_i,
  input logic [NCH-1:0] status_o
);
  assert_restart_all_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i || inact_to_i) |=> (status_o == '1));

  assert_mask_moves_only_on_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(soft_rst_i || inact_to_i || smp_pulse) |=> $stable(status_o));

  assert_no_reenable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(soft_rst_i || inact_to_i) |=> ((status_o & ~$past(status_o)) == '0));

  assert_all_blocked_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == '0) |-> !data_o);

  assert_carrier_ungated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o == '0) && (carrier_i != '0)) |-> carrier_o);
endmodule

bind auto_chan_gate auto_chan_gate_chk #(.NCH(NCH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .inact_to_i(inact_to_i),
  .smp_pulse(smp_pulse), .data_o(data_o), .carrier_o(carrier_o),
  .carrier_i(carrier_i), .status_o(status_o)
);

// File: tb/test_auto_chan_gate.sv
module test_auto_chan_gate;
  localparam int unsigned NCH = 3;
  localparam int unsigned ST  = 3;
  localparam int unsigned RW  = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick_i = 0, soft_rst_i = 0, inact_to_i = 0, auto_en_i = 0;
  logic [NCH-1:0] demod_i = '0, carrier_i = '0;
  logic [RW-1:0] rssi_i = '0;
  logic data_o, carrier_o;
  logic [RW-1:0] rssi_o;
  logic [NCH-1:0] status_o;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  auto_chan_gate #(.NCH(NCH), .SETTLE_TICKS(ST), .RSSI_W(RW)) i_auto_chan_gate (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .soft_rst_i(soft_rst_i),
    .inact_to_i(inact_to_i), .auto_en_i(auto_en_i), .demod_i(demod_i),
    .carrier_i(carrier_i), .rssi_i(rssi_i), .data_o(data_o), .carrier_o(carrier_o),
    .rssi_o(rssi_o), .status_o(status_o)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_dem(logic [NCH-1:0] v);
    demod_i = v; step(); step();
  endtask

  task automatic restart(bit inact);
    if (inact) inact_to_i = 1; else soft_rst_i = 1;
    step();
    inact_to_i = 0; soft_rst_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1; step(); tick_i = 0; step();
    end
  endtask

  task automatic data_sweep(logic [NCH-1:0] m, string req);
    for (int q = 0; q < 8; q++) begin
      set_dem(NCH'(q));
      chk(req, data_o, |(NCH'(q) & m));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_ni = 1; step();
    chk("R1", status_o, 3'b111);
    chk("R1", data_o, 0);

    for (int en = 0; en < 2; en++) begin
      for (int p = 0; p < 8; p++) begin
        logic [NCH-1:0] exp_m;
        exp_m = en ? NCH'(p) : 3'b111;
        auto_en_i = 1'(en);
        set_dem(NCH'(p));
        restart(p[0]);
        chk("R2", status_o, 3'b111);
        ticks(ST - 1);
        chk("R3", status_o, 3'b111);
        ticks(1);
        chk(en ? "R4" : "R5", status_o, exp_m);
        data_sweep(exp_m, "R7");
        set_dem(~NCH'(p));
        ticks(ST + 1);
        chk("R6", status_o, exp_m);
      end
    end

    // enable flips mid-period: period latched enabled
    auto_en_i = 1; set_dem(3'b010); restart(0);
    auto_en_i = 0; ticks(ST);
    chk("R5", status_o, 3'b010);
    // period latched disabled, enable raised mid-period
    restart(0); auto_en_i = 1; ticks(ST);
    chk("R5", status_o, 3'b111);

    // fully blocked, then inactivity timeout re-enables
    restart(0); set_dem(3'b000); ticks(ST);
    chk("R4", status_o, 3'b000);
    carrier_i = 3'b100; rssi_i = 8'hA5; #1;
    chk("R8", carrier_o, 1);
    chk("R8", rssi_o, 8'hA5);
    carrier_i = 3'b000; rssi_i = 8'h3C; #1;
    chk("R8", carrier_o, 0);
    chk("R8", rssi_o, 8'h3C);
    set_dem(3'b111);
    chk("R7", data_o, 0);
    restart(1);
    chk("R2", status_o, 3'b111);
    chk("R7", data_o, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule